// File: doc/BRIEF.md
# Dual-Chip NOR Flash Operation Sequencer

This block runs the full command sequence for one flash operation on a 32-bit memory-mapped bus. Behind the bus sit two 16-bit NOR flash chips side by side, so each chip sees its own half of every word. The host picks one of four operations: word program, block erase, block lock or block unlock. It supplies a target address and, for program, a 32-bit data word, and then pulses `start_i`. The sequencer issues the command writes, polls the ready status of both chips within a retry budget set for that operation, and classifies the final status. It always finishes by putting the flash back into array-read mode.

Every command code is placed in both 16-bit halves of the written word, so both chips receive it in the same access. Ready counts only when both halves report it. Error checks use the OR of the two halves, so a fault on either chip is seen. The result comes out as a 2-bit code together with a one-cycle completion pulse.

The memory side is a single-beat request port. A request, with its direction, address and write data, is held until the memory lowers its wait signal. The memory can therefore stall any access for any number of cycles.

Top module: `nor_seq`

## Requirements
- R1: Every command write places the 8-bit command code in bits 7:0 and in bits 23:16 of the word, with all other bits zero. The codes are 0x50 clear status, 0x70 read status, 0x40 program, 0x20 erase setup, 0xD0 erase confirm or unlock, 0x60 lock setup, 0x01 lock and 0xFF read array.
- R2: The first bus access of every operation is a write of clear status (0x50).
- R3: After the clear-status write, each operation writes in this order. Program (op 0) writes 0x40, then the raw data word. Erase (op 1) writes 0x20, then 0xD0. Lock (op 2) writes 0x60, then 0x01. Unlock (op 3) writes 0x60, then 0xD0.
- R4: Each poll attempt is a read-status write followed by one bus read. Polling succeeds only when bit 7 and bit 23 of the read word are both 1.
- R5: When no attempt succeeds, the operation ends with result 3 (timeout) after exactly budget+1 attempts. The budgets are 1000 for program, 3000000 for erase and 1000 for lock/unlock by default, each a parameter.
- R6: After ready, program does one extra status read. If the OR of both 16-bit halves has bit 4 (program error) or bit 1 (block locked) set, program writes clear status, reports result 1 and skips the final check.
- R7: The final check does a read-status write and a read, then takes the OR of the two halves. It reports 1 if bit 4, 1, 6 or 2 is set; otherwise 2 if bit 3 or bit 5 is set; otherwise 0.
- R8: The last bus write of every operation, timeout included, is read array (0xFF). It is followed by a one-cycle `done_o` pulse, with `busy_o` low and `result_o` valid.
- R9: A request is held with stable direction, address and write data while `bus_wait_i` is high. It completes in the cycle where `bus_wait_i` is low. All accesses target the latched operation address, and no request is made while idle.
- R10: A start pulse while busy is ignored: the running operation's accesses, address and result are unchanged.
- R11: After reset the block is idle, with no bus request and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_i | input | 2 | 0 program, 1 erase, 2 lock, 3 unlock |
| addr_i | input | ADDR_W | Target address for the operation |
| data_i | input | 32 | Word to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 protection, 2 I/O error, 3 timeout |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, sampled when the access completes |
| bus_wait_i | input | 1 | Stall: the access does not complete while high |

## Verification
The assertions assume that `bus_wait_i` only delays an access and never cancels it, and that `bus_rdata_i` is valid in the cycle a read completes. The bench's memory model follows both rules: it sets the wait level and the status word on the falling edge, using a pseudo-random stall pattern. The assertions also assume that start is a pulse given while idle. The bench drives start for exactly one cycle. Its only start pulses during a busy phase are the deliberate ones that test that start is ignored.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } nor_op_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_PROT = 2'd1,
    RES_IO   = 2'd2,
    RES_TMO  = 2'd3
  } nor_res_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLR,
    S_SETUP,
    S_ACTION,
    S_POLL_CMD,
    S_POLL_RD,
    S_PCHK_CMD,
    S_PCHK_RD,
    S_PCLR,
    S_FCHK_CMD,
    S_FCHK_RD,
    S_RESTORE
  } seq_state_e;

  // status register bit positions, per chip
  localparam int SR_READY    = 7;
  localparam int SR_ERS_SUSP = 6;
  localparam int SR_ERS_ERR  = 5;
  localparam int SR_PGM_ERR  = 4;
  localparam int SR_VPP_ERR  = 3;
  localparam int SR_PGM_SUSP = 2;
  localparam int SR_LOCKED   = 1;

endpackage

// File: rtl/nor_bus_port.sv
module nor_bus_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_wait_i
);

  logic              req_q, we_q, ack_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (req_q) begin
        if (!bus_wait_i) begin
          req_q <= 1'b0;
          ack_q <= 1'b1;
          if (!we_q) rdata_q <= bus_rdata_i;
        end
      end else if (issue_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;

endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval
  import nor_seq_pkg::*;
#(
  parameter int CHIP_W = 16,
  localparam int DATA_W = 2 * CHIP_W
) (
  input  logic [DATA_W-1:0] rdata_i,
  output logic              both_ready_o,
  output logic              pgm_fail_o,
  output nor_res_e          class_o
);

  localparam logic [CHIP_W-1:0] PGM_MASK =
    CHIP_W'((1 << SR_PGM_ERR) | (1 << SR_LOCKED));
  localparam logic [CHIP_W-1:0] PROT_MASK =
    CHIP_W'((1 << SR_PGM_ERR) | (1 << SR_LOCKED) | (1 << SR_ERS_SUSP) | (1 << SR_PGM_SUSP));
  localparam logic [CHIP_W-1:0] IO_MASK =
    CHIP_W'((1 << SR_VPP_ERR) | (1 << SR_ERS_ERR));

  logic [CHIP_W-1:0] lo, hi, merged;

  assign lo     = rdata_i[CHIP_W-1:0];
  assign hi     = rdata_i[DATA_W-1:CHIP_W];
  assign merged = lo | hi;

  assign both_ready_o = lo[SR_READY] & hi[SR_READY];
  assign pgm_fail_o   = |(merged & PGM_MASK);

  always_comb begin
    if (|(merged & PROT_MASK))    class_o = RES_PROT;
    else if (|(merged & IO_MASK)) class_o = RES_IO;
    else                          class_o = RES_OK;
  end

endmodule

// File: rtl/nor_retry_ctr.sv
module nor_retry_ctr
  import nor_seq_pkg::*;
#(
  parameter int PROG_RETRIES  = 1000,
  parameter int ERASE_RETRIES = 3000000,
  parameter int LOCK_RETRIES  = 1000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    load_i,
  input  nor_op_e op_i,
  input  logic    dec_i,
  output logic    expired_o
);

  localparam int MAX_A = (PROG_RETRIES > LOCK_RETRIES) ? PROG_RETRIES : LOCK_RETRIES;
  localparam int MAX_R = (ERASE_RETRIES > MAX_A) ? ERASE_RETRIES : MAX_A;
  localparam int CNT_W = $clog2(MAX_R + 2);

  logic [CNT_W-1:0] cnt_q, budget;

  always_comb begin
    unique case (op_i)
      OP_PROG:  budget = CNT_W'(PROG_RETRIES);
      OP_ERASE: budget = CNT_W'(ERASE_RETRIES);
      default:  budget = CNT_W'(LOCK_RETRIES);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= budget;
    else if (dec_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          CHIP_W       = 16,
  parameter logic [7:0]  CMD_RD_STAT  = 8'h70,
  parameter logic [7:0]  CMD_CLR_STAT = 8'h50,
  parameter logic [7:0]  CMD_PROG     = 8'h40,
  parameter logic [7:0]  CMD_ERS_SET  = 8'h20,
  parameter logic [7:0]  CMD_ERS_CONF = 8'hD0,
  parameter logic [7:0]  CMD_LCK_SET  = 8'h60,
  parameter logic [7:0]  CMD_LOCK     = 8'h01,
  parameter logic [7:0]  CMD_UNLOCK   = 8'hD0,
  parameter logic [7:0]  CMD_RD_ARRAY = 8'hFF,
  localparam int DATA_W = 2 * CHIP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  nor_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  input  logic              both_ready_i,
  input  logic              pgm_fail_i,
  input  nor_res_e          class_i,
  input  logic              expired_i,
  output logic              issue_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              load_o,
  output logic              dec_o,
  output logic              busy_o,
  output logic              done_o,
  output nor_res_e          result_o
);

  function automatic logic [DATA_W-1:0] dup(input logic [7:0] c);
    return {{(CHIP_W-8){1'b0}}, c, {(CHIP_W-8){1'b0}}, c};
  endfunction

  seq_state_e        state_q, state_d;
  nor_res_e          res_q, res_d;
  nor_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              pend_q, done_q, done_d;
  logic              is_read;

  assign is_read = (state_q == S_POLL_RD) || (state_q == S_PCHK_RD) || (state_q == S_FCHK_RD);
  assign issue_o = (state_q != S_IDLE) && !pend_q;
  assign we_o    = !is_read;
  assign addr_o  = addr_q;
  assign load_o  = (state_q == S_IDLE) && start_i;
  assign dec_o   = ack_i && (state_q == S_POLL_RD) && !both_ready_i && !expired_i;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign result_o = res_q;

  always_comb begin
    unique case (state_q)
      S_CLR, S_PCLR: wdata_o = dup(CMD_CLR_STAT);
      S_SETUP: begin
        unique case (op_q)
          OP_PROG:  wdata_o = dup(CMD_PROG);
          OP_ERASE: wdata_o = dup(CMD_ERS_SET);
          default:  wdata_o = dup(CMD_LCK_SET);
        endcase
      end
      S_ACTION: begin
        unique case (op_q)
          OP_PROG:   wdata_o = data_q;
          OP_ERASE:  wdata_o = dup(CMD_ERS_CONF);
          OP_LOCK:   wdata_o = dup(CMD_LOCK);
          default:   wdata_o = dup(CMD_UNLOCK);
        endcase
      end
      S_POLL_CMD, S_PCHK_CMD, S_FCHK_CMD: wdata_o = dup(CMD_RD_STAT);
      S_RESTORE: wdata_o = dup(CMD_RD_ARRAY);
      default:   wdata_o = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    done_d  = 1'b0;
    if (state_q == S_IDLE) begin
      if (start_i) state_d = S_CLR;
    end else if (ack_i) begin
      unique case (state_q)
        S_CLR:      state_d = S_SETUP;
        S_SETUP:    state_d = S_ACTION;
        S_ACTION:   state_d = S_POLL_CMD;
        S_POLL_CMD: state_d = S_POLL_RD;
        S_POLL_RD: begin
          if (both_ready_i)   state_d = (op_q == OP_PROG) ? S_PCHK_CMD : S_FCHK_CMD;
          else if (expired_i) begin
            res_d   = RES_TMO;
            state_d = S_RESTORE;
          end else            state_d = S_POLL_CMD;
        end
        S_PCHK_CMD: state_d = S_PCHK_RD;
        S_PCHK_RD: begin
          if (pgm_fail_i) begin
            res_d   = RES_PROT;
            state_d = S_PCLR;
          end else state_d = S_FCHK_CMD;
        end
        S_PCLR:     state_d = S_RESTORE;
        S_FCHK_CMD: state_d = S_FCHK_RD;
        S_FCHK_RD: begin
          res_d   = class_i;
          state_d = S_RESTORE;
        end
        S_RESTORE: begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      res_q   <= RES_OK;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      done_q  <= done_d;
      if (issue_o)    pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      if (load_o) begin
        op_q   <= op_i;
        addr_q <= addr_i;
        data_q <= data_i;
        res_q  <= RES_OK;
      end
    end
  end

endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int          ADDR_W        = 32,
  parameter int          CHIP_W        = 16,
  parameter int          PROG_RETRIES  = 1000,
  parameter int          ERASE_RETRIES = 3000000,
  parameter int          LOCK_RETRIES  = 1000,
  parameter logic [7:0]  CMD_RD_STAT   = 8'h70,
  parameter logic [7:0]  CMD_CLR_STAT  = 8'h50,
  parameter logic [7:0]  CMD_PROG      = 8'h40,
  parameter logic [7:0]  CMD_ERS_SET   = 8'h20,
  parameter logic [7:0]  CMD_ERS_CONF  = 8'hD0,
  parameter logic [7:0]  CMD_LCK_SET   = 8'h60,
  parameter logic [7:0]  CMD_LOCK      = 8'h01,
  parameter logic [7:0]  CMD_UNLOCK    = 8'hD0,
  parameter logic [7:0]  CMD_RD_ARRAY  = 8'hFF,
  localparam int DATA_W = 2 * CHIP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_wait_i
);

  logic              issue, we, ack, load, dec, expired, both_ready, pgm_fail;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata, rdata;
  nor_res_e          cls, res;
  nor_op_e           op;

  assign op       = nor_op_e'(op_i);
  assign result_o = res;

  nor_seq_ctrl #(
    .ADDR_W(ADDR_W), .CHIP_W(CHIP_W),
    .CMD_RD_STAT(CMD_RD_STAT), .CMD_CLR_STAT(CMD_CLR_STAT), .CMD_PROG(CMD_PROG),
    .CMD_ERS_SET(CMD_ERS_SET), .CMD_ERS_CONF(CMD_ERS_CONF), .CMD_LCK_SET(CMD_LCK_SET),
    .CMD_LOCK(CMD_LOCK), .CMD_UNLOCK(CMD_UNLOCK), .CMD_RD_ARRAY(CMD_RD_ARRAY)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i(op), .addr_i, .data_i,
    .ack_i(ack), .both_ready_i(both_ready), .pgm_fail_i(pgm_fail), .class_i(cls),
    .expired_i(expired), .issue_o(issue), .we_o(we), .addr_o(acc_addr),
    .wdata_o(acc_wdata), .load_o(load), .dec_o(dec), .busy_o, .done_o, .result_o(res)
  );

  nor_retry_ctr #(
    .PROG_RETRIES(PROG_RETRIES), .ERASE_RETRIES(ERASE_RETRIES), .LOCK_RETRIES(LOCK_RETRIES)
  ) u_retry (
    .clk_i, .rst_ni, .load_i(load), .op_i(op), .dec_i(dec), .expired_o(expired)
  );

  nor_status_eval #(.CHIP_W(CHIP_W)) u_eval (
    .rdata_i(rdata), .both_ready_o(both_ready), .pgm_fail_o(pgm_fail), .class_o(cls)
  );

  nor_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i, .rst_ni, .issue_i(issue), .we_i(we), .addr_i(acc_addr), .wdata_i(acc_wdata),
    .ack_o(ack), .rdata_o(rdata), .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_rdata_i, .bus_wait_i
  );

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int         ADDR_W       = 32,
  parameter int         CHIP_W       = 16,
  parameter logic [7:0] CMD_RD_ARRAY = 8'hFF
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  bus_req_o,
  input logic                  bus_we_o,
  input logic [ADDR_W-1:0]     bus_addr_o,
  input logic [2*CHIP_W-1:0]   bus_wdata_o,
  input logic                  bus_wait_i
);

  localparam logic [2*CHIP_W-1:0] RA_WORD =
    {{(CHIP_W-8){1'b0}}, CMD_RD_ARRAY, {(CHIP_W-8){1'b0}}, CMD_RD_ARRAY};

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_wait_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)
                                 && $stable(bus_wdata_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_last_read_array_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_req_o, 2) && $past(bus_we_o, 2) && !$past(bus_wait_i, 2)
                      && $past(bus_wdata_o, 2) == RA_WORD);

endmodule

bind nor_seq nor_seq_chk #(
  .ADDR_W(ADDR_W), .CHIP_W(CHIP_W), .CMD_RD_ARRAY(CMD_RD_ARRAY)
) u_chk (
  .clk_i, .rst_ni, .busy_o, .done_o, .bus_req_o, .bus_we_o, .bus_addr_o,
  .bus_wdata_o, .bus_wait_i
);

// File: tb/nor_seq_test.sv
module nor_seq_test;

  localparam int PR = 4, ER = 6, LR = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] addr = '0, data = '0;
  logic        busy, done, req, we;
  logic [1:0]  result;
  logic [31:0] baddr, wdata, rdata = '0;
  logic        bwait = 1'b0;

  always #2 clk = ~clk;

  nor_seq #(.PROG_RETRIES(PR), .ERASE_RETRIES(ER), .LOCK_RETRIES(LR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .data_i(data), .busy_o(busy), .done_o(done), .result_o(result),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(baddr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_wait_i(bwait)
  );

  int checks = 0, fails = 0, done_cnt = 0, rd_cnt = 0, exp_reads = 0;
  logic [31:0] exp_wr[$];
  logic [1:0]  exp_res[$];
  logic [31:0] cur_addr;
  int          rdy_at;
  bit          lo_ok, hi_ok, prev_done = 0, finished = 0;
  logic [7:0]  e_lo, e_hi;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] dup(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: computes the expected trace from the requirements
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] d,
                        input int ra, input bit lok, input bit hok,
                        input logic [7:0] el, input logic [7:0] eh, input bit poke);
    int budget, polls, reads, target;
    logic [1:0] res;
    logic [7:0] m;
    budget = (o == 2'd0) ? PR : (o == 2'd1) ? ER : LR;
    m = el | eh;
    exp_wr.push_back(dup(8'h50));                                   // R2
    case (o)                                                        // R3
      2'd0: begin exp_wr.push_back(dup(8'h40)); exp_wr.push_back(d); end
      2'd1: begin exp_wr.push_back(dup(8'h20)); exp_wr.push_back(dup(8'hD0)); end
      2'd2: begin exp_wr.push_back(dup(8'h60)); exp_wr.push_back(dup(8'h01)); end
      default: begin exp_wr.push_back(dup(8'h60)); exp_wr.push_back(dup(8'hD0)); end
    endcase
    if (lok && hok && ra <= budget + 1) polls = ra; else polls = budget + 1;   // R4 R5
    for (int i = 0; i < polls; i++) exp_wr.push_back(dup(8'h70));
    reads = polls;
    if (!(lok && hok && ra <= budget + 1)) res = 2'd3;
    else begin
      res = 2'd0;
      if (o == 2'd0) begin                                          // R6
        exp_wr.push_back(dup(8'h70)); reads++;
        if ((m & 8'h12) != 0) begin exp_wr.push_back(dup(8'h50)); res = 2'd1; end
      end
      if (res == 2'd0) begin                                        // R7
        exp_wr.push_back(dup(8'h70)); reads++;
        if ((m & 8'h56) != 0) res = 2'd1;
        else if ((m & 8'h28) != 0) res = 2'd2;
      end
    end
    exp_wr.push_back(dup(8'hFF));                                   // R8
    exp_res.push_back(res);
    exp_reads = reads;
    rd_cnt = 0; rdy_at = ra; lo_ok = lok; hi_ok = hok; e_lo = el; e_hi = eh;
    cur_addr = a;
    target = done_cnt + 1;
    @(negedge clk);
    op = o; addr = a; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin                                                 // R10
      repeat (6) @(negedge clk);
      op = 2'd1; addr = ~a; data = ~d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (9) @(negedge clk);
      op = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      bit w;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w = lfsr[0] & lfsr[3];
      bwait = w;
      if (req && !w) begin
        check(baddr == cur_addr, "R9 address", baddr, cur_addr);
        if (we) begin
          if (exp_wr.size() == 0) check(0, "R3 unexpected write", wdata, 32'h0);
          else begin
            logic [31:0] e;
            e = exp_wr.pop_front();
            check(wdata == e, "R1 R3 write", wdata, e);
          end
        end else begin
          int idx;
          bit r;
          idx = rd_cnt + 1;
          r = idx >= rdy_at;
          rdata = {8'h00, {r & hi_ok, 7'b0} | e_hi, 8'h00, {r & lo_ok, 7'b0} | e_lo};
          rd_cnt++;
        end
      end
      check(!(prev_done && done), "R8 done width", 32'(done), 32'd0);
      if (done) begin
        if (exp_res.size() == 0) check(0, "R10 extra done", 32'(result), 32'h0);
        else begin
          logic [1:0] er;
          er = exp_res.pop_front();
          check(result == er, "R5 R6 R7 result", 32'(result), 32'(er));
        end
        check(!busy, "R8 busy at done", 32'(busy), 32'd0);
        check(rd_cnt == exp_reads, "R4 read count", 32'(rd_cnt), 32'(exp_reads));
        check(exp_wr.size() == 0, "R8 writes left", 32'(exp_wr.size()), 32'd0);
        done_cnt++;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !req, "R11 reset state", {29'b0, busy, done, req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !req, "R11 idle after reset", {30'b0, busy, req}, 32'd0);
    run_op(2'd0, 32'h0004_0000, 32'h1234_ABCD, 3, 1, 1, 8'h00, 8'h00, 0); // ok
    run_op(2'd0, 32'h0004_0010, 32'hFFFF_0000, 2, 1, 1, 8'h10, 8'h00, 0); // PS lo
    run_op(2'd0, 32'h0004_0020, 32'h0F0F_F0F0, 1, 1, 1, 8'h00, 8'h02, 0); // BLS hi
    run_op(2'd0, 32'h0004_0030, 32'h5555_AAAA, 2, 1, 1, 8'h40, 8'h00, 0); // ESS
    run_op(2'd0, 32'h0004_0040, 32'h0000_0001, PR + 1, 1, 1, 8'h00, 8'h00, 0); // last try
    run_op(2'd1, 32'h0008_0000, 32'h0, 1, 1, 1, 8'h00, 8'h00, 0);          // erase ok
    run_op(2'd1, 32'h0008_0100, 32'h0, 4, 1, 1, 8'h00, 8'h08, 0);          // VPP hi
    run_op(2'd1, 32'h0008_0200, 32'h0, 2, 1, 1, 8'h20, 8'h04, 0);          // ES+PSS
    run_op(2'd1, 32'h0008_0300, 32'h0, 1, 1, 0, 8'h00, 8'h00, 0);          // timeout
    run_op(2'd2, 32'h000C_0000, 32'h0, LR + 1, 1, 1, 8'h00, 8'h00, 0);     // lock ok
    run_op(2'd2, 32'h000C_0100, 32'h0, LR + 2, 1, 1, 8'h00, 8'h00, 0);     // lock timeout
    run_op(2'd3, 32'h0010_0000, 32'h0, 2, 1, 1, 8'h20, 8'h00, 1);          // unlock io, pokes
    run_op(2'd3, 32'h0010_0100, 32'h0, 1, 0, 1, 8'h00, 8'h00, 0);          // lo never ready
    check(done_cnt == 13, "R10 done count", 32'(done_cnt), 32'd13);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d done expected 13", done_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule